// File: doc/BRIEF.md
# Thread Block Occupancy Admission Controller

This block sits in front of one multiprocessor and decides, request by request, whether a new thread block can become resident there. Four independent pools are tracked: thread contexts, resident block slots, the register file and shared-memory bytes. A request carries the block's thread count, its registers per thread and its shared-memory bytes. It is accepted only when every pool can cover its cost at the same time. On acceptance all four amounts are reserved at once, and the block receives the lowest free slot id. A block never holds part of its resources, so whichever pool runs out first limits how many blocks are resident.

A legal request that does not fit yet is held: ready stays low until completions return enough resources. A request that could never be legal gets an error response and reserves nothing. A completion names a slot and returns everything that slot holds. A completion and a request may arrive in the same cycle. The release is applied first, so the freed resources, and the freed slot id, are already available to that request. The current free amount of each pool is visible on status outputs.

Top module: `blk_admit`

## Requirements
- R1: After reset the free outputs read 768 thread contexts, 8 slots, 8192 registers and 16384 shared bytes, and no response or completion error is signalled.
- R2: Thread contexts are charged in whole warps of 32: an admitted block with t threads lowers the thread-context pool by t rounded up to the next multiple of 32.
- R3: An admitted block lowers the register pool by its thread count multiplied by its registers per thread (the thread count is not rounded for this).
- R4: An admitted block lowers the shared-memory pool by exactly its requested byte count.
- R5: An admitted block takes one slot, and the response returns the lowest-numbered slot that is free after any same-cycle release. At most 8 blocks are resident.
- R6: A legal request that does not fit in all four pools keeps req_ready_o low and changes no pool; it is admitted in the first cycle in which every pool covers it.
- R7: A request is illegal when its thread count is 0 or above 512, when threads times registers per thread exceeds 8192, or when its shared bytes exceed 16384. It is accepted at once with ready high, answered with rsp_err_o set, and changes no pool.
- R8: rsp_valid_o is high for exactly the one cycle after each request handshake, with rsp_err_o and rsp_slot_o describing that request.
- R9: A completion for an allocated slot returns to each pool exactly the amounts that slot reserved, and frees the slot.
- R10: A completion for a slot that is not allocated raises done_err_o in the following cycle and leaves every pool unchanged.
- R11: When a completion and a request arrive in the same cycle, the release is applied before the admission check, so a request that fits only with the released resources is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Admission request present |
| req_ready_o | output | 1 | Request accepted this cycle (admitted or rejected as illegal) |
| req_threads_i | input | 10 | Threads in the block |
| req_rpt_i | input | 8 | Registers per thread |
| req_smem_i | input | 15 | Shared-memory bytes for the block |
| rsp_valid_o | output | 1 | Response for the request accepted last cycle |
| rsp_err_o | output | 1 | Request was illegal |
| rsp_slot_o | output | 3 | Slot id given to an admitted block |
| done_valid_i | input | 1 | Block completion present |
| done_slot_i | input | 3 | Slot id of the completing block |
| done_err_o | output | 1 | Completion named a slot that was not allocated |
| free_thr_o | output | 10 | Free thread contexts |
| free_slots_o | output | 4 | Free block slots |
| free_regs_o | output | 14 | Free registers |
| free_smem_o | output | 15 | Free shared-memory bytes |

## Verification
The bench drives each pool in turn to the point where it is the one that binds: threads, slots, registers and shared memory. A design that checked only some pools, or reserved part of a block, would let the next request through or shift a pool it should leave alone. Requests of 1, 100 and 320 threads test warp rounding. A design that charged raw thread counts would drift the thread pool off multiples of 32. Same-cycle completion and request pairs test the release-first order. A design that checked before releasing would hold a request that should pass, or give out a higher slot id than the one just freed. Illegal requests at 0 and 513 threads, register and shared-memory overflows, and completions to idle slots must all leave every pool untouched.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  localparam int unsigned DEF_THR_TOTAL   = 768;
  localparam int unsigned DEF_SLOTS       = 8;
  localparam int unsigned DEF_REG_TOTAL   = 8192;
  localparam int unsigned DEF_SMEM_TOTAL  = 16384;
  localparam int unsigned DEF_BLK_THR_MAX = 512;
  localparam int unsigned DEF_WARP        = 32;
  localparam int unsigned DEF_RPT_W       = 8;
endpackage

// File: rtl/blk_cost.sv
module blk_cost #(
  parameter int unsigned THR_W       = 10,
  parameter int unsigned RPT_W       = 8,
  parameter int unsigned SMEM_W      = 15,
  parameter int unsigned THRC_W      = 10,
  parameter int unsigned REGC_W      = 14,
  parameter int unsigned SMC_W       = 15,
  parameter int unsigned WARP        = 32,
  parameter int unsigned BLK_THR_MAX = 512,
  parameter int unsigned THR_TOTAL   = 768,
  parameter int unsigned REG_TOTAL   = 8192,
  parameter int unsigned SMEM_TOTAL  = 16384
) (
  input  logic [THR_W-1:0]  thr_i,
  input  logic [RPT_W-1:0]  rpt_i,
  input  logic [SMEM_W-1:0] smem_i,
  output logic [THRC_W-1:0] thr_need_o,
  output logic [REGC_W-1:0] reg_need_o,
  output logic [SMC_W-1:0]  smem_need_o,
  output logic              illegal_o
);
  localparam int unsigned RW = THR_W + RPT_W;
  localparam int unsigned CW = THR_W + 1;
  localparam logic [CW-1:0]     WMASK   = CW'(WARP - 1);
  localparam logic [THR_W-1:0]  BMAX    = THR_W'(BLK_THR_MAX);
  localparam logic [CW-1:0]     TTOT    = CW'(THR_TOTAL);
  localparam logic [RW-1:0]     RTOT    = RW'(REG_TOTAL);
  localparam logic [SMEM_W-1:0] STOT    = SMEM_W'(SMEM_TOTAL);

  logic [CW-1:0] chg;
  logic [RW-1:0] reg_full;

  // R2: round up to whole warps (WARP is a power of two)
  assign chg      = (CW'(thr_i) + WMASK) & ~WMASK;
  // R3: register cost uses the raw thread count
  assign reg_full = RW'(thr_i) * RW'(rpt_i);

  // R7
  assign illegal_o = (thr_i == '0) || (thr_i > BMAX) || (reg_full > RTOT) ||
                     (smem_i > STOT) || (chg > TTOT);

  assign thr_need_o  = THRC_W'(chg);
  assign reg_need_o  = REGC_W'(reg_full);
  assign smem_need_o = SMC_W'(smem_i);
endmodule

// File: rtl/blk_pool.sv
module blk_pool #(
  parameter int unsigned W     = 10,
  parameter int unsigned TOTAL = 768
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rel_i,
  input  logic [W-1:0] rel_amt_i,
  input  logic         take_i,
  input  logic [W-1:0] need_i,
  output logic         fit_o,
  output logic [W-1:0] free_o
);
  logic [W-1:0] free_q, avail;

  // R11: release is folded in before the fit check
  assign avail  = free_q + (rel_i ? rel_amt_i : '0);
  assign fit_o  = avail >= need_i;
  assign free_o = free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     free_q <= W'(TOTAL);
    else if (take_i) free_q <= avail - need_i;
    else             free_q <= avail;
  end
endmodule

// File: rtl/blk_slot_tbl.sv
module blk_slot_tbl #(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned ID_W   = 3,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned THRC_W = 10,
  parameter int unsigned REGC_W = 14,
  parameter int unsigned SMC_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rel_i,
  input  logic [ID_W-1:0]   rel_id_i,
  input  logic              take_i,
  input  logic [THRC_W-1:0] thr_i,
  input  logic [REGC_W-1:0] reg_i,
  input  logic [SMC_W-1:0]  smem_i,
  output logic              rel_busy_o,
  output logic [THRC_W-1:0] rel_thr_o,
  output logic [REGC_W-1:0] rel_reg_o,
  output logic [SMC_W-1:0]  rel_smem_o,
  output logic              pick_ok_o,
  output logic [ID_W-1:0]   pick_id_o,
  output logic [CNT_W-1:0]  free_cnt_o
);
  logic [SLOTS-1:0]  busy_q, cand;
  logic [THRC_W-1:0] thr_q  [SLOTS];
  logic [REGC_W-1:0] reg_q  [SLOTS];
  logic [SMC_W-1:0]  smem_q [SLOTS];

  assign rel_busy_o = busy_q[rel_id_i];
  assign rel_thr_o  = thr_q[rel_id_i];
  assign rel_reg_o  = reg_q[rel_id_i];
  assign rel_smem_o = smem_q[rel_id_i];

  // R5, R11: a slot released this cycle is already a candidate
  always_comb begin
    for (int i = 0; i < SLOTS; i++)
      cand[i] = !busy_q[i] || (rel_i && (rel_id_i == ID_W'(i)));
  end

  always_comb begin
    pick_id_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (cand[i]) pick_id_o = ID_W'(i);
  end
  assign pick_ok_o = |cand;

  always_comb begin
    free_cnt_o = '0;
    for (int i = 0; i < SLOTS; i++)
      free_cnt_o = free_cnt_o + CNT_W'(!busy_q[i]);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic set_s, clr_s;
    assign set_s = take_i && (pick_id_o == ID_W'(g));
    assign clr_s = rel_i && (rel_id_i == ID_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[g] <= 1'b0;
        thr_q[g]  <= '0;
        reg_q[g]  <= '0;
        smem_q[g] <= '0;
      end else if (set_s) begin
        busy_q[g] <= 1'b1;
        thr_q[g]  <= thr_i;
        reg_q[g]  <= reg_i;
        smem_q[g] <= smem_i;
      end else if (clr_s) begin
        busy_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blk_admit.sv
module blk_admit
  import blk_admit_pkg::*;
#(
  parameter int unsigned THR_TOTAL   = DEF_THR_TOTAL,
  parameter int unsigned SLOTS       = DEF_SLOTS,
  parameter int unsigned REG_TOTAL   = DEF_REG_TOTAL,
  parameter int unsigned SMEM_TOTAL  = DEF_SMEM_TOTAL,
  parameter int unsigned BLK_THR_MAX = DEF_BLK_THR_MAX,
  parameter int unsigned WARP        = DEF_WARP,
  parameter int unsigned RPT_W       = DEF_RPT_W,
  localparam int unsigned THR_W  = $clog2(BLK_THR_MAX) + 1,
  localparam int unsigned SMEM_W = $clog2(SMEM_TOTAL) + 1,
  localparam int unsigned ID_W   = $clog2(SLOTS),
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1),
  localparam int unsigned THRC_W = $clog2(THR_TOTAL + 1),
  localparam int unsigned REGC_W = $clog2(REG_TOTAL + 1),
  localparam int unsigned SMC_W  = $clog2(SMEM_TOTAL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [THR_W-1:0]  req_threads_i,
  input  logic [RPT_W-1:0]  req_rpt_i,
  input  logic [SMEM_W-1:0] req_smem_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [ID_W-1:0]   rsp_slot_o,
  input  logic              done_valid_i,
  input  logic [ID_W-1:0]   done_slot_i,
  output logic              done_err_o,
  output logic [THRC_W-1:0] free_thr_o,
  output logic [CNT_W-1:0]  free_slots_o,
  output logic [REGC_W-1:0] free_regs_o,
  output logic [SMC_W-1:0]  free_smem_o
);
  logic [THRC_W-1:0] thr_need, rel_thr;
  logic [REGC_W-1:0] reg_need, rel_reg;
  logic [SMC_W-1:0]  smem_need, rel_smem;
  logic illegal, rel_busy, rel_ok, pick_ok;
  logic thr_fit, reg_fit, smem_fit, fits_all, fire, take;
  logic [ID_W-1:0] pick_id;

  blk_cost #(
    .THR_W(THR_W), .RPT_W(RPT_W), .SMEM_W(SMEM_W), .THRC_W(THRC_W),
    .REGC_W(REGC_W), .SMC_W(SMC_W), .WARP(WARP), .BLK_THR_MAX(BLK_THR_MAX),
    .THR_TOTAL(THR_TOTAL), .REG_TOTAL(REG_TOTAL), .SMEM_TOTAL(SMEM_TOTAL)
  ) cost_i (
    .thr_i(req_threads_i), .rpt_i(req_rpt_i), .smem_i(req_smem_i),
    .thr_need_o(thr_need), .reg_need_o(reg_need), .smem_need_o(smem_need),
    .illegal_o(illegal)
  );

  blk_slot_tbl #(
    .SLOTS(SLOTS), .ID_W(ID_W), .CNT_W(CNT_W),
    .THRC_W(THRC_W), .REGC_W(REGC_W), .SMC_W(SMC_W)
  ) tbl_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rel_i(rel_ok), .rel_id_i(done_slot_i),
    .take_i(take), .thr_i(thr_need), .reg_i(reg_need), .smem_i(smem_need),
    .rel_busy_o(rel_busy), .rel_thr_o(rel_thr), .rel_reg_o(rel_reg),
    .rel_smem_o(rel_smem), .pick_ok_o(pick_ok), .pick_id_o(pick_id),
    .free_cnt_o(free_slots_o)
  );

  blk_pool #(.W(THRC_W), .TOTAL(THR_TOTAL)) thr_pool_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rel_i(rel_ok), .rel_amt_i(rel_thr),
    .take_i(take), .need_i(thr_need), .fit_o(thr_fit), .free_o(free_thr_o)
  );

  blk_pool #(.W(REGC_W), .TOTAL(REG_TOTAL)) reg_pool_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rel_i(rel_ok), .rel_amt_i(rel_reg),
    .take_i(take), .need_i(reg_need), .fit_o(reg_fit), .free_o(free_regs_o)
  );

  blk_pool #(.W(SMC_W), .TOTAL(SMEM_TOTAL)) smem_pool_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rel_i(rel_ok), .rel_amt_i(rel_smem),
    .take_i(take), .need_i(smem_need), .fit_o(smem_fit), .free_o(free_smem_o)
  );

  // R10: completions to idle slots are dropped
  assign rel_ok = done_valid_i && rel_busy;

  // R6: all pools together, or nothing
  assign fits_all    = thr_fit && reg_fit && smem_fit && pick_ok;
  assign req_ready_o = illegal || fits_all;
  assign fire        = req_valid_i && req_ready_o;
  assign take        = fire && !illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_slot_o  <= '0;
      done_err_o  <= 1'b0;
    end else begin
      rsp_valid_o <= fire;
      rsp_err_o   <= fire && illegal;
      rsp_slot_o  <= take ? pick_id : '0;
      done_err_o  <= done_valid_i && !rel_busy;
    end
  end
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned WARP   = 32,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned THRC_W = 10,
  parameter int unsigned REGC_W = 14,
  parameter int unsigned SMC_W  = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              done_valid_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic              done_err_o,
  input logic [THRC_W-1:0] free_thr_o,
  input logic [CNT_W-1:0]  free_slots_o,
  input logic [REGC_W-1:0] free_regs_o,
  input logic [SMC_W-1:0]  free_smem_o
);
  // R5
  slots_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_slots_o <= CNT_W'(SLOTS));

  // R2
  warp_gran_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_thr_o % THRC_W'(WARP)) == '0);

  // R8
  rsp_after_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  // R8
  rsp_only_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);

  // R6
  hold_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o && !done_valid_i) |=>
      ($stable(free_slots_o) && $stable(free_thr_o) && $stable(free_regs_o) && $stable(free_smem_o)));

  // R7
  illegal_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !done_valid_i) |=> (!rsp_err_o ||
      ($stable(free_slots_o) && $stable(free_thr_o) && $stable(free_regs_o) && $stable(free_smem_o))));

  // R10
  stray_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && !(req_valid_i && req_ready_o)) |=> (!done_err_o ||
      ($stable(free_slots_o) && $stable(free_thr_o) && $stable(free_regs_o) && $stable(free_smem_o))));
endmodule

bind blk_admit blk_admit_chk #(
  .SLOTS(SLOTS), .WARP(WARP), .CNT_W(CNT_W),
  .THRC_W(THRC_W), .REGC_W(REGC_W), .SMC_W(SMC_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .done_valid_i(done_valid_i), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
  .done_err_o(done_err_o), .free_thr_o(free_thr_o), .free_slots_o(free_slots_o),
  .free_regs_o(free_regs_o), .free_smem_o(free_smem_o)
);

// File: tb/blk_admit_tb_top.sv
module blk_admit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [9:0]  req_threads = '0;
  logic [7:0]  req_rpt = '0;
  logic [14:0] req_smem = '0;
  logic rsp_valid, rsp_err, done_err;
  logic [2:0] rsp_slot;
  logic done_valid = 1'b0;
  logic [2:0] done_slot = '0;
  logic [9:0]  free_thr;
  logic [3:0]  free_slots;
  logic [13:0] free_regs;
  logic [14:0] free_smem;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_busy [8];
  int m_thr [8], m_reg [8], m_smem [8];
  int f_thr = 768, f_slots = 8, f_reg = 8192, f_smem = 16384;

  always #5 clk = ~clk;

  blk_admit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_threads_i(req_threads), .req_rpt_i(req_rpt), .req_smem_i(req_smem),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_slot_o(rsp_slot),
    .done_valid_i(done_valid), .done_slot_i(done_slot), .done_err_o(done_err),
    .free_thr_o(free_thr), .free_slots_o(free_slots),
    .free_regs_o(free_regs), .free_smem_o(free_smem)
  );

  task automatic check(input string req, input string ctx, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, ctx, act, exp);
    end
  endtask

  task automatic check_free(input string ctx);
    check("R2", ctx, int'(free_thr), f_thr);
    check("R5", ctx, int'(free_slots), f_slots);
    check("R3", ctx, int'(free_regs), f_reg);
    check("R4", ctx, int'(free_smem), f_smem);
  endtask

  // one clock: drive at negedge, check ready, update model at posedge, check outputs next negedge
  task automatic cyc(input int v, input int t, input int r, input int s,
                     input int dv, input int ds, input string ctx);
    bit rel, illegal, fit, exp_ready, fire, was_busy;
    int chg, rc, at, ar, asm, asl, pick;
    req_valid = (v != 0); req_threads = 10'(t); req_rpt = 8'(r); req_smem = 15'(s);
    done_valid = (dv != 0); done_slot = 3'(ds);
    #1;
    was_busy = m_busy[ds];
    rel = (dv != 0) && was_busy;
    at  = f_thr   + (rel ? m_thr[ds]  : 0);
    ar  = f_reg   + (rel ? m_reg[ds]  : 0);
    asm = f_smem  + (rel ? m_smem[ds] : 0);
    asl = f_slots + (rel ? 1 : 0);
    chg = ((t + 31) / 32) * 32;
    rc  = t * r;
    illegal = (t == 0) || (t > 512) || (rc > 8192) || (s > 16384);
    fit = (chg <= at) && (rc <= ar) && (s <= asm) && (asl > 0);
    exp_ready = illegal || fit;
    check("R6", ctx, int'(req_ready), int'(exp_ready));
    fire = (v != 0) && exp_ready;
    pick = 0;
    for (int i = 7; i >= 0; i--)
      if (!m_busy[i] || (rel && i == ds)) pick = i;
    @(posedge clk);
    if (rel) begin
      m_busy[ds] = 1'b0; f_thr = at; f_reg = ar; f_smem = asm; f_slots = asl;
    end
    if (fire && !illegal) begin
      m_busy[pick] = 1'b1; m_thr[pick] = chg; m_reg[pick] = rc; m_smem[pick] = s;
      f_thr -= chg; f_reg -= rc; f_smem -= s; f_slots -= 1;
    end
    @(negedge clk);
    check("R8", ctx, int'(rsp_valid), int'(fire));
    if (fire) check("R7", ctx, int'(rsp_err), int'(illegal));
    if (fire && !illegal) check("R5", ctx, int'(rsp_slot), pick);
    check("R10", ctx, int'(done_err), int'((dv != 0) && !was_busy));
    check_free(ctx);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check("R1", "reset", int'(rsp_valid), 0);
    check("R1", "reset", int'(done_err), 0);
    check("R1", "reset thr", int'(free_thr), 768);
    check("R1", "reset slots", int'(free_slots), 8);
    check("R1", "reset regs", int'(free_regs), 8192);
    check("R1", "reset smem", int'(free_smem), 16384);
    rst_n = 1'b1;
    @(negedge clk);
    idle();

    // R2 R3 R4: 100 threads charge 128 contexts, 1000 regs, 1000 bytes
    cyc(1, 100, 10, 1000, 0, 0, "R2 basic admit");
    // R7: illegal shapes
    cyc(1, 513, 1, 0, 0, 0, "R7 too many threads");
    cyc(1, 0, 1, 0, 0, 0, "R7 zero threads");
    cyc(1, 512, 20, 0, 0, 0, "R7 register overflow");
    cyc(1, 32, 1, 20000, 0, 0, "R7 smem overflow");
    // thread pool binds
    cyc(1, 320, 4, 0, 0, 0, "R2 fill");
    cyc(1, 320, 4, 0, 0, 0, "R2 fill");
    cyc(1, 1, 1, 0, 0, 0, "R6 thread held");
    cyc(1, 1, 1, 0, 0, 0, "R6 thread held");
    // R10: completion to idle slot
    cyc(1, 1, 1, 0, 1, 5, "R10 stray done");
    // R11: release slot 1 and admit in the same cycle
    cyc(1, 320, 4, 0, 1, 1, "R11 same cycle");
    // R9: release everything
    cyc(0, 0, 0, 0, 1, 0, "R9 release");
    cyc(0, 0, 0, 0, 1, 1, "R9 release");
    cyc(0, 0, 0, 0, 1, 2, "R9 release");
    cyc(0, 0, 0, 0, 1, 2, "R10 double release");

    // R5: slot limit binds
    for (int k = 0; k < 8; k++) cyc(1, 32, 1, 0, 0, 0, "R5 slot fill");
    cyc(1, 32, 1, 0, 0, 0, "R6 slot held");
    cyc(1, 32, 1, 0, 1, 4, "R11 slot reuse");
    for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 1, k, "R9 drain");

    // R3: register pool binds
    cyc(1, 256, 32, 0, 0, 0, "R3 regs full");
    cyc(1, 32, 1, 0, 0, 0, "R6 regs held");
    cyc(1, 33, 1, 0, 1, 0, "R11 regs");
    cyc(0, 0, 0, 0, 1, 0, "R9 drain");

    // R4: shared memory binds
    cyc(1, 64, 2, 16384, 0, 0, "R4 smem full");
    cyc(1, 32, 1, 1, 0, 0, "R6 smem held");
    cyc(0, 0, 0, 0, 1, 0, "R9 smem back");
    cyc(1, 32, 1, 1, 0, 0, "R6 smem admit");
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule